// File: doc/BRIEF.md
# Double-Data-Rate Four-Beat Burst SRAM Read Path

This block models the read side of a synchronous SRAM that moves data only in groups of four words at double data rate. It runs on one internal clock at twice the command rate. An internal half-cycle phase bit marks every edge as either a command-clock rising edge or a complementary-clock rising edge. Commands are sampled only on command-clock rising edges. An accepted read fetches four words from an internal array and drives them on the data bus, one word per half cycle, after a fixed latency.

The block also drives a pair of complementary echo strobes. They are registered on the same edges as the data, so a receiver can use them to capture the words. While no burst word is on the bus, the data-valid output is low and the data bus is held at zero. A synchronous preload port fills the array before reads begin.

A burst fills two full command cycles. For this reason a read request in the command cycle directly after an accepted read is dropped, and an error pulse reports it. Idle cycles and write-direction commands never disturb a burst that is already in flight.

Top module: `ddr_burst4_rd`

## Requirements
- R1: Every accepted read produces exactly four data words on four consecutive edges. The data-valid output `rdata_oe` is high for a multiple of four consecutive cycles.
- R2: A read is accepted when `req_n` is 0 and `dir_rd` is 1 at a command-clock rising edge. `cmd_addr` is captured at that edge. A request that is present only at a complementary edge is ignored.
- R3: Take the accepting edge as E0. The first word is registered at E3, which is a complementary edge 1.5 command cycles later. The remaining words follow at E4, E5 and E6. `rdata_oe` is low after E1 and E2 when the block was idle.
- R4: Beat k (k = 0..3) reads the array word whose address is the captured upper bits (`cmd_addr[AW-1:2]`) joined with (`cmd_addr[1:0]` + k) mod 4. The burst therefore wraps inside an aligned group of four.
- R5: A read request at the command edge directly after an accepted read is not started. `burst_err` is 1 for exactly the one cycle after that edge.
- R6: A read at the next-but-one command edge (E4) is accepted. Its four words follow the previous four with no gap (E7..E10), and `rdata_oe` stays high across all eight.
- R7: A command edge with `req_n` = 1 (no operation), or with `req_n` = 0 and `dir_rd` = 0 (write direction), neither shortens nor alters a burst in flight. A write-direction command starts nothing, raises no error and leaves the array unchanged.
- R8: Whenever `rdata_oe` is 0, `rdata` is all zeros.
- R9: `echo_p` is 1 after every command-clock rising edge and 0 after every complementary edge. `echo_n` is always its complement. The first word of a burst is therefore driven with `echo_p` = 0.
- R10: While `rst` is high, `rdata_oe`, `rdata` and `burst_err` are 0, `echo_p` is 0 and `echo_n` is 1. A burst in flight is discarded. The first edge after reset is released is a command-clock rising edge.
- R11: When `pre_we` is 1 at an edge, `pre_wdata` is written to array word `pre_addr`, and later reads return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the command rate |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | 1 | Active-low command strobe, sampled on command edges |
| dir_rd | input | 1 | Direction: 1 = read, 0 = write (ignored) |
| cmd_addr | input | AW | Burst start address |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | AW | Preload word address |
| pre_wdata | input | DW | Preload write data |
| rdata | output | DW | Burst data, one word per half cycle |
| rdata_oe | output | 1 | High while a burst word is driven |
| echo_p | output | 1 | Echo strobe, high after command-clock edges |
| echo_n | output | 1 | Complement of `echo_p` |
| burst_err | output | 1 | One-cycle pulse for a dropped read request |

## Verification
The hardest case to reach is the overlap at E4 of back-to-back bursts. At that edge the sequencer issues the fourth array read of the old burst and captures the new burst's address in the same cycle. Between those two reads, a request in the forbidden slot has to be seen and dropped. The bench reaches this state by aligning to a command edge through the echo strobe and then placing three requests two half cycles apart: accept, reject, accept. It then checks that the eight words arrive without a gap and that the error pulse lands on the rejected edge. A separate sequence places a request only across a complementary edge and confirms that nothing starts.

// File: rtl/b4rd_pkg.sv
package b4rd_pkg;
  localparam int BEATS = 4;

  typedef enum logic {
    PH_KRISE = 1'b0,
    PH_KFALL = 1'b1
  } half_e;
endpackage

// File: rtl/b4rd_ctl.sv
module b4rd_ctl
  import b4rd_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_n,
  input  logic          dir_rd,
  input  logic [AW-1:0] cmd_addr,
  output half_e         phase,
  output logic          burst_err,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr
);
  localparam int OW = $clog2(BEATS);
  localparam int HW = AW - OW;

  logic [HW-1:0] base_hi;
  logic [OW-1:0] base_lo;
  logic [OW-1:0] beat;
  logic          act;
  logic          acc_last;
  logic          krise;
  logic          rd_req;
  logic          start;

  // half-cycle phase: command edge, then complementary edge
  always_ff @(posedge clk) begin
    if (rst) phase <= PH_KRISE;
    else     phase <= (phase == PH_KRISE) ? PH_KFALL : PH_KRISE;
  end

  assign krise  = (phase == PH_KRISE);
  assign rd_req = !req_n && dir_rd;
  assign start  = krise && rd_req && !acc_last;

  // remembers whether the previous command edge accepted a read
  always_ff @(posedge clk) begin
    if (rst)        acc_last <= 1'b0;
    else if (krise) acc_last <= start;
  end

  always_ff @(posedge clk) begin
    if (rst) burst_err <= 1'b0;
    else     burst_err <= krise && rd_req && acc_last;
  end

  // beat sequencer: one array read per half cycle
  always_ff @(posedge clk) begin
    if (start) begin
      base_hi <= cmd_addr[AW-1:OW];
      base_lo <= cmd_addr[OW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act  <= 1'b0;
      beat <= '0;
    end else if (start) begin
      act  <= 1'b1;
      beat <= '0;
    end else if (act) begin
      beat <= beat + 1'b1;
      if (beat == OW'(BEATS - 1)) act <= 1'b0;
    end
  end

  assign rd_en   = act;
  assign rd_addr = {base_hi, OW'(base_lo + beat)};
endmodule

// File: rtl/b4rd_array.sv
module b4rd_array #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q,
  output logic          rd_v
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_v <= 1'b0;
    else     rd_v <= rd_en;
  end
endmodule

// File: rtl/b4rd_out.sv
module b4rd_out
  import b4rd_pkg::*;
#(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  half_e         phase,
  input  logic [DW-1:0] in_q,
  input  logic          in_v,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe,
  output logic          echo_p,
  output logic          echo_n
);
  logic [DW-1:0] stg_q;
  logic          stg_v;

  // stage register behind the array output register
  always_ff @(posedge clk) begin
    stg_q <= in_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_v    <= 1'b0;
      rdata    <= '0;
      rdata_oe <= 1'b0;
      echo_p   <= 1'b0;
      echo_n   <= 1'b1;
    end else begin
      stg_v    <= in_v;
      rdata    <= stg_v ? stg_q : '0;
      rdata_oe <= stg_v;
      echo_p   <= (phase == PH_KRISE);
      echo_n   <= (phase != PH_KRISE);
    end
  end
endmodule

// File: rtl/ddr_burst4_rd.sv
module ddr_burst4_rd
  import b4rd_pkg::*;
#(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_n,
  input  logic          dir_rd,
  input  logic [AW-1:0] cmd_addr,
  input  logic          pre_we,
  input  logic [AW-1:0] pre_addr,
  input  logic [DW-1:0] pre_wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe,
  output logic          echo_p,
  output logic          echo_n,
  output logic          burst_err
);
  half_e         phase;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] arr_q;
  logic          arr_v;

  b4rd_ctl #(.AW(AW)) u_ctl (
    .clk(clk), .rst(rst), .req_n(req_n), .dir_rd(dir_rd), .cmd_addr(cmd_addr),
    .phase(phase), .burst_err(burst_err), .rd_en(rd_en), .rd_addr(rd_addr)
  );

  b4rd_array #(.DW(DW), .AW(AW)) u_arr (
    .clk(clk), .rst(rst), .wr_en(pre_we), .wr_addr(pre_addr), .wr_data(pre_wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_q(arr_q), .rd_v(arr_v)
  );

  b4rd_out #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .phase(phase), .in_q(arr_q), .in_v(arr_v),
    .rdata(rdata), .rdata_oe(rdata_oe), .echo_p(echo_p), .echo_n(echo_n)
  );
endmodule

// File: rtl/b4rd_chk.sv
module b4rd_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst,
  input logic          req_n,
  input logic          dir_rd,
  input logic [DW-1:0] rdata,
  input logic          rdata_oe,
  input logic          echo_p,
  input logic          echo_n,
  input logic          burst_err
);
  logic [1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) run_cnt <= '0;
    else     run_cnt <= rdata_oe ? run_cnt + 2'd1 : 2'd0;
  end

  AST_BURST_FOUR: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(rdata_oe)) |-> ($past(run_cnt) == 2'd3)); // R1
  AST_FIRST_ON_KFALL: assert property (@(posedge clk) disable iff (rst)
    $rose(rdata_oe) |-> !echo_p); // R3
  AST_FIRST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    $rose(rdata_oe) |-> $past(!req_n && dir_rd && !echo_p, 4)); // R3
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    burst_err |-> $past(!req_n && dir_rd && !echo_p)); // R5
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    burst_err |=> !burst_err); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rdata_oe |-> (rdata == '0)); // R8
  AST_ECHO_PAIR: assert property (@(posedge clk) disable iff (rst)
    echo_p != echo_n); // R9
  AST_ECHO_ALT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (echo_p != $past(echo_p))); // R9
endmodule

bind ddr_burst4_rd b4rd_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .req_n(req_n), .dir_rd(dir_rd), .rdata(rdata),
  .rdata_oe(rdata_oe), .echo_p(echo_p), .echo_n(echo_n), .burst_err(burst_err)
);

// File: tb/ddr_burst4_rd_bench.sv
module ddr_burst4_rd_bench;
  localparam int DW = 18;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int NV = 8;
  localparam logic [AW-1:0] VEC [NV] = '{8'h00, 8'h01, 8'h02, 8'h03,
                                         8'h46, 8'hFD, 8'h9A, 8'hFF};

  logic          clk = 1'b0;
  logic          rst;
  logic          req_n;
  logic          dir_rd;
  logic [AW-1:0] cmd_addr;
  logic          pre_we;
  logic [AW-1:0] pre_addr;
  logic [DW-1:0] pre_wdata;
  logic [DW-1:0] rdata;
  logic          rdata_oe;
  logic          echo_p;
  logic          echo_n;
  logic          burst_err;

  logic [DW-1:0] shadow [DEPTH];
  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  ddr_burst4_rd #(.DW(DW), .AW(AW)) u_ddr_burst4_rd (
    .clk(clk), .rst(rst), .req_n(req_n), .dir_rd(dir_rd), .cmd_addr(cmd_addr),
    .pre_we(pre_we), .pre_addr(pre_addr), .pre_wdata(pre_wdata),
    .rdata(rdata), .rdata_oe(rdata_oe), .echo_p(echo_p), .echo_n(echo_n),
    .burst_err(burst_err)
  );

  function automatic logic [DW-1:0] pat(int i);
    return DW'((i * 1103 + 77) ^ (i << 7));
  endfunction

  function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] a, int k);
    return {a[AW-1:2], 2'(a[1:0] + k)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // leaves the bench at a negedge whose next posedge is a command edge
  task automatic to_krise();
    while (echo_p !== 1'b0) @(negedge clk);
  endtask

  task automatic preload(input logic [AW-1:0] a, input logic [DW-1:0] d);
    pre_we = 1'b1; pre_addr = a; pre_wdata = d;
    @(negedge clk);
    pre_we = 1'b0;
    shadow[a] = d;
  endtask

  // single read, then walks edges E0..E7
  task automatic run_burst(input logic [AW-1:0] a);
    to_krise();
    req_n = 1'b0; dir_rd = 1'b1; cmd_addr = a;
    for (int e = 0; e < 8; e++) begin
      @(negedge clk);
      if (e == 0) begin req_n = 1'b1; cmd_addr = ~a; end
      if (e == 1 || e == 2) check("R3 idle before first word", 32'(rdata_oe), 32'd0);
      if (e >= 3 && e <= 6) begin
        check("R1 oe during burst", 32'(rdata_oe), 32'd1);
        check("R4 wrapped beat data", 32'(rdata), 32'(shadow[beat_addr(a, e - 3)]));
        check("R9 echo alignment", 32'(echo_p), (e % 2 == 0) ? 32'd1 : 32'd0);
      end
      if (e == 7) begin
        check("R1 oe low after four beats", 32'(rdata_oe), 32'd0);
        check("R8 data zero when idle", 32'(rdata), 32'd0);
      end
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic seen;
    rst = 1'b1; req_n = 1'b1; dir_rd = 1'b1; cmd_addr = '0;
    pre_we = 1'b0; pre_addr = '0; pre_wdata = '0;
    repeat (3) @(negedge clk);
    check("R10 reset oe", 32'(rdata_oe), 32'd0);
    check("R10 reset data", 32'(rdata), 32'd0);
    check("R10 reset err", 32'(burst_err), 32'd0);
    check("R10 reset echo_p", 32'(echo_p), 32'd0);
    check("R10 reset echo_n", 32'(echo_n), 32'd1);
    for (int i = 0; i < DEPTH; i++) preload(AW'(i), pat(i));
    rst = 1'b0;
    @(negedge clk);
    check("R10 first edge is command edge", 32'(echo_p), 32'd1);
    check("R9 echo complement", 32'(echo_n), 32'd0);

    // table walk: R1 R3 R4 R8 R9
    for (int v = 0; v < NV; v++) run_burst(VEC[v]);

    // R11: overwrite one word, then read its group
    to_krise();
    preload(8'h31, 18'h2A5C3);
    run_burst(8'h30);

    // R5 / R6: accept, reject, accept
    to_krise();
    req_n = 1'b0; dir_rd = 1'b1; cmd_addr = 8'h12;
    for (int e = 0; e < 12; e++) begin
      @(negedge clk);
      if (e == 0) req_n = 1'b1;
      if (e == 1) begin req_n = 1'b0; cmd_addr = 8'h55; end
      if (e == 2) req_n = 1'b1;
      if (e == 3) begin req_n = 1'b0; cmd_addr = 8'h2B; end
      if (e == 4) req_n = 1'b1;
      if (e == 2) check("R5 error pulse", 32'(burst_err), 32'd1);
      if (e == 3) check("R5 error one cycle", 32'(burst_err), 32'd0);
      if (e >= 3 && e <= 6) check("R5 first burst intact", 32'(rdata), 32'(shadow[beat_addr(8'h12, e - 3)]));
      if (e >= 7 && e <= 10) check("R6 second burst data", 32'(rdata), 32'(shadow[beat_addr(8'h2B, e - 7)]));
      if (e >= 3 && e <= 10) check("R6 oe continuous", 32'(rdata_oe), 32'd1);
      if (e == 11) check("R6 oe low after eight", 32'(rdata_oe), 32'd0);
    end

    // R7: write-direction command during a burst
    to_krise();
    req_n = 1'b0; dir_rd = 1'b1; cmd_addr = 8'h6E;
    for (int e = 0; e < 8; e++) begin
      @(negedge clk);
      if (e == 0) req_n = 1'b1;
      if (e == 1) begin req_n = 1'b0; dir_rd = 1'b0; cmd_addr = 8'h20; end
      if (e == 2) begin req_n = 1'b1; dir_rd = 1'b1; end
      if (e == 2) check("R7 no error on write cmd", 32'(burst_err), 32'd0);
      if (e >= 3 && e <= 6) check("R7 burst undisturbed", 32'(rdata), 32'(shadow[beat_addr(8'h6E, e - 3)]));
      if (e == 7) check("R7 no extra burst", 32'(rdata_oe), 32'd0);
    end
    run_burst(8'h20); // R7 array unchanged by write command

    // R2: request present only at a complementary edge
    to_krise();
    @(negedge clk);
    req_n = 1'b0; dir_rd = 1'b1; cmd_addr = 8'h44;
    @(negedge clk);
    req_n = 1'b1;
    seen = 1'b0;
    for (int e = 0; e < 8; e++) begin
      @(negedge clk);
      if (rdata_oe) seen = 1'b1;
    end
    check("R2 complementary edge ignored", 32'(seen), 32'd0);

    // R10: reset in the middle of a burst
    to_krise();
    req_n = 1'b0; dir_rd = 1'b1; cmd_addr = 8'h88;
    for (int e = 0; e < 4; e++) begin
      @(negedge clk);
      if (e == 0) req_n = 1'b1;
    end
    check("R10 burst running before reset", 32'(rdata_oe), 32'd1);
    rst = 1'b1;
    @(negedge clk);
    check("R10 oe cleared", 32'(rdata_oe), 32'd0);
    check("R10 data cleared", 32'(rdata), 32'd0);
    check("R10 echo_p cleared", 32'(echo_p), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 command edge after release", 32'(echo_p), 32'd1);
    seen = 1'b0;
    for (int e = 0; e < 6; e++) begin
      @(negedge clk);
      if (rdata_oe) seen = 1'b1;
    end
    check("R10 pipeline flushed", 32'(seen), 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule